// File: doc/BRIEF.md
# Nonvolatile Store/Recall Power Sequencer

This block sits beside an SRAM that keeps a nonvolatile shadow copy. It decides when the shadow is copied into the SRAM (recall) and when the SRAM is copied into the shadow (store). It drives one-cycle start strobes to the nonvolatile array and tells the rest of the memory when accesses must be held off.

When the supply comparator reports a good supply, the block starts a recall and keeps memory access shut for a fixed number of cycles. While the supply stays good, the serial command decoder can ask for a software store or recall, or can switch automatic saving on loss of power on or off.

When the supply fails, the block accepts no further commands. A write that is already completing gets a short grace window. After that the block saves the SRAM into the shadow, but only if the SRAM has been written since the last recall or store and automatic saving is enabled. All durations are cycle-count parameters.

Top module: `nvseq_top`

## Requirements
- R1: While powered down, a high `supply_ok` starts a power-up recall. `nv_recall_go` pulses in the cycle after it is sampled, and `busy` and `access_off` stay high for exactly `TFA` cycles. After that, `access_off` and `busy` are both low.
- R2: Once `supply_ok` is sampled low in the ready state, the block leaves the ready state, and commands are ignored until the next power-up recall has finished.
- R3: If `wr_pending` is high when the supply drop is sampled, `access_off` stays low for `TDELAY` cycles. Writes in that window still count. The store decision is then taken, and a store strobe follows in the next cycle.
- R4: On power loss, a store (`nv_store_go` pulse, then `busy` for `TSTORE` cycles) starts only if the SRAM is dirty and automatic saving is enabled. Otherwise the block goes straight to powered down with no strobe.
- R5: `standby` is high exactly when `cs_n` is high and the block is ready with no store or recall running.
- R6: A software store holds `busy` for `TSTORE` cycles and a software recall for `TRECALL` cycles. Each starts with its strobe in the cycle after the command.
- R7: A `wr_pulse` accepted while access is open marks the SRAM dirty. Completion of any store or recall clears the mark.
- R8: `cmd_as_off` disables automatic saving and `cmd_as_on` enables it. Every power-up recall re-enables it.
- R9: Store and recall commands that arrive while a cycle is running are ignored. When both arrive together in the ready state, the store wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply comparator: high when supply is above threshold |
| cs_n | input | 1 | Chip select, active low |
| wr_pending | input | 1 | A write has received its last data bit and is still completing |
| wr_pulse | input | 1 | One-cycle pulse per SRAM write |
| cmd_store | input | 1 | Software store command strobe |
| cmd_recall | input | 1 | Software recall command strobe |
| cmd_as_on | input | 1 | Enable automatic save on power loss |
| cmd_as_off | input | 1 | Disable automatic save on power loss |
| busy | output | 1 | A store or recall is running |
| access_off | output | 1 | Memory accesses are inhibited |
| standby | output | 1 | Standby power mode |
| nv_store_go | output | 1 | Start strobe: SRAM into shadow |
| nv_recall_go | output | 1 | Start strobe: shadow into SRAM |

## Verification
The bench targets the windows whose ends are easy to misplace. It checks the last busy cycle and the first idle cycle of every recall and store; an off-by-one counter would show `busy` one cycle early or late. It drops the supply with a clean SRAM, including right after a store has cleared a dirty mark, and with automatic saving switched off; a design that ignored either condition would emit a store strobe the monitor does not expect. It also drops the supply with a write still completing and marks the SRAM dirty only inside the grace window. A design that cut access at once, forgot late writes or accepted a command during the window would show the wrong `access_off` value or a missing or extra strobe.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_PU_RECALL  = 3'd1,
        ST_READY      = 3'd2,
        ST_SW_STORE   = 3'd3,
        ST_SW_RECALL  = 3'd4,
        ST_GRACE      = 3'd5,
        ST_AUTO_STORE = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic store;
        logic recall;
        logic as_on;
        logic as_off;
    } seq_cmd_t;

    typedef struct packed {
        logic store_go;
        logic recall_go;
    } nv_go_t;

    function automatic logic state_busy(seq_state_e s);
        return (s == ST_PU_RECALL) || (s == ST_SW_STORE) ||
               (s == ST_SW_RECALL) || (s == ST_AUTO_STORE);
    endfunction

    function automatic logic state_open(seq_state_e s);
        return (s == ST_READY) || (s == ST_GRACE);
    endfunction

    function automatic integer max_of4(integer a, integer b, integer c, integer d);
        integer m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    AST_TMR_LOADS: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val))); // R6

endmodule

// File: rtl/nvseq_flags.sv
module nvseq_flags (
    input  logic clk,
    input  logic rst,
    input  logic wr_pulse,
    input  logic wr_open,
    input  logic clr_dirty,
    input  logic pu_start,
    input  logic as_set,
    input  logic as_clr,
    output logic dirty_now,
    output logic as_en
);
    logic dirty;
    logic wr_seen;

    assign wr_seen = wr_pulse && wr_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty <= 1'b0;
        end else if (clr_dirty) begin
            dirty <= 1'b0;
        end else if (wr_seen) begin
            dirty <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            as_en <= 1'b1;
        end else if (pu_start) begin
            as_en <= 1'b1;
        end else if (as_clr) begin
            as_en <= 1'b0;
        end else if (as_set) begin
            as_en <= 1'b1;
        end
    end

    // a write in the deciding cycle still counts
    assign dirty_now = dirty || wr_seen;

    AST_DIRTY_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr_dirty |=> !dirty); // R7
    AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (rst)
        (wr_seen && !clr_dirty) |=> dirty); // R7
    AST_AS_DEFAULT_ON: assert property (@(posedge clk) disable iff (rst)
        pu_start |=> as_en); // R8
    AST_AS_TURNS_OFF: assert property (@(posedge clk) disable iff (rst)
        (as_clr && !pu_start) |=> !as_en); // R8

endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
    import nvseq_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int TFA     = 10,
    parameter int TDELAY  = 4,
    parameter int TSTORE  = 6,
    parameter int TRECALL = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             wr_pending,
    input  seq_cmd_t         cmd,
    input  logic             dirty_now,
    input  logic             as_en,
    input  logic             tmr_expired,
    output seq_state_e       state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output nv_go_t           go,
    output logic             cycle_done,
    output logic             pu_start,
    output logic             cmd_open,
    output logic             wr_open
);
    localparam logic [CNT_W-1:0] TFA_V     = CNT_W'(TFA - 1);
    localparam logic [CNT_W-1:0] TDELAY_V  = CNT_W'(TDELAY - 1);
    localparam logic [CNT_W-1:0] TSTORE_V  = CNT_W'(TSTORE - 1);
    localparam logic [CNT_W-1:0] TRECALL_V = CNT_W'(TRECALL - 1);

    seq_state_e nxt;
    nv_go_t     go_n;
    logic       save_ok;

    assign save_ok  = dirty_now && as_en;
    assign cmd_open = (state == ST_READY) && supply_ok;
    assign wr_open  = state_open(state);

    always_comb begin
        nxt        = state;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        go_n       = '0;
        cycle_done = 1'b0;
        pu_start   = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (supply_ok) begin
                    nxt            = ST_PU_RECALL;
                    tmr_load       = 1'b1;
                    tmr_val        = TFA_V;
                    go_n.recall_go = 1'b1;
                    pu_start       = 1'b1;
                end
            end
            ST_PU_RECALL: begin
                if (!supply_ok) begin
                    nxt = ST_OFF;
                end else if (tmr_expired) begin
                    nxt        = ST_READY;
                    cycle_done = 1'b1;
                end
            end
            ST_READY: begin
                if (!supply_ok) begin
                    if (wr_pending) begin
                        nxt      = ST_GRACE;
                        tmr_load = 1'b1;
                        tmr_val  = TDELAY_V;
                    end else if (save_ok) begin
                        nxt           = ST_AUTO_STORE;
                        tmr_load      = 1'b1;
                        tmr_val       = TSTORE_V;
                        go_n.store_go = 1'b1;
                    end else begin
                        nxt = ST_OFF;
                    end
                end else if (cmd.store) begin
                    nxt           = ST_SW_STORE;
                    tmr_load      = 1'b1;
                    tmr_val       = TSTORE_V;
                    go_n.store_go = 1'b1;
                end else if (cmd.recall) begin
                    nxt            = ST_SW_RECALL;
                    tmr_load       = 1'b1;
                    tmr_val        = TRECALL_V;
                    go_n.recall_go = 1'b1;
                end
            end
            ST_SW_STORE, ST_SW_RECALL: begin
                if (tmr_expired) begin
                    cycle_done = 1'b1;
                    nxt        = supply_ok ? ST_READY : ST_OFF;
                end
            end
            ST_GRACE: begin
                if (tmr_expired) begin
                    if (save_ok) begin
                        nxt           = ST_AUTO_STORE;
                        tmr_load      = 1'b1;
                        tmr_val       = TSTORE_V;
                        go_n.store_go = 1'b1;
                    end else begin
                        nxt = ST_OFF;
                    end
                end
            end
            ST_AUTO_STORE: begin
                if (tmr_expired) begin
                    cycle_done = 1'b1;
                    nxt        = ST_OFF;
                end
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            go    <= '0;
        end else begin
            state <= nxt;
            go    <= go_n;
        end
    end

    AST_PU_RECALL_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && supply_ok) |=> (state == ST_PU_RECALL && go.recall_go)); // R1
    AST_DROP_LEAVES_READY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY && !supply_ok) |=> (state != ST_READY)); // R2
    AST_GRACE_ON_PENDING: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY && !supply_ok && wr_pending) |=> (state == ST_GRACE)); // R3
    AST_CLEAN_NO_SAVE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY && !supply_ok && !wr_pending && !save_ok) |=> !go.store_go); // R4
    AST_BUSY_NO_NEW_GO: assert property (@(posedge clk) disable iff (rst)
        (state_busy(state) && !tmr_expired) |=> !(go.store_go || go.recall_go)); // R9

endmodule

// File: rtl/nvseq_top.sv
module nvseq_top
    import nvseq_pkg::*;
#(
    parameter int TFA     = 10,
    parameter int TDELAY  = 4,
    parameter int TSTORE  = 6,
    parameter int TRECALL = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic cs_n,
    input  logic wr_pending,
    input  logic wr_pulse,
    input  logic cmd_store,
    input  logic cmd_recall,
    input  logic cmd_as_on,
    input  logic cmd_as_off,
    output logic busy,
    output logic access_off,
    output logic standby,
    output logic nv_store_go,
    output logic nv_recall_go
);
    localparam int LONGEST = max_of4(TFA, TDELAY, TSTORE, TRECALL);
    localparam int CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

    seq_cmd_t         cmd;
    seq_state_e       state;
    nv_go_t           go;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cycle_done;
    logic             pu_start;
    logic             cmd_open;
    logic             wr_open;
    logic             dirty_now;
    logic             as_en;

    assign cmd = '{store: cmd_store, recall: cmd_recall,
                   as_on: cmd_as_on, as_off: cmd_as_off};

    nvseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    nvseq_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .wr_pulse  (wr_pulse),
        .wr_open   (wr_open),
        .clr_dirty (cycle_done),
        .pu_start  (pu_start),
        .as_set    (cmd.as_on && cmd_open),
        .as_clr    (cmd.as_off && cmd_open),
        .dirty_now (dirty_now),
        .as_en     (as_en)
    );

    nvseq_fsm #(
        .CNT_W   (CNT_W),
        .TFA     (TFA),
        .TDELAY  (TDELAY),
        .TSTORE  (TSTORE),
        .TRECALL (TRECALL)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .wr_pending  (wr_pending),
        .cmd         (cmd),
        .dirty_now   (dirty_now),
        .as_en       (as_en),
        .tmr_expired (tmr_expired),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .go          (go),
        .cycle_done  (cycle_done),
        .pu_start    (pu_start),
        .cmd_open    (cmd_open),
        .wr_open     (wr_open)
    );

    assign busy         = state_busy(state);
    assign access_off   = !state_open(state);
    assign standby      = cs_n && (state == ST_READY);
    assign nv_store_go  = go.store_go;
    assign nv_recall_go = go.recall_go;

    AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (rst)
        standby |-> !busy); // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nv_store_go, nv_recall_go})); // R9

endmodule

// File: tb/nvseq_top_test.sv
module nvseq_top_test;
    localparam int TFA     = 10;
    localparam int TDELAY  = 4;
    localparam int TSTORE  = 6;
    localparam int TRECALL = 5;
    localparam int K_STORE  = 1;
    localparam int K_RECALL = 2;

    logic clk = 1'b0;
    logic rst, supply_ok, cs_n, wr_pending, wr_pulse;
    logic cmd_store, cmd_recall, cmd_as_on, cmd_as_off;
    logic busy, access_off, standby, nv_store_go, nv_recall_go;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int exp_kind[$];
    int exp_cyc[$];
    string exp_req[$];
    int got_kind;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nvseq_top #(.TFA(TFA), .TDELAY(TDELAY), .TSTORE(TSTORE), .TRECALL(TRECALL)) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_n(cs_n),
        .wr_pending(wr_pending), .wr_pulse(wr_pulse),
        .cmd_store(cmd_store), .cmd_recall(cmd_recall),
        .cmd_as_on(cmd_as_on), .cmd_as_off(cmd_as_off),
        .busy(busy), .access_off(access_off), .standby(standby),
        .nv_store_go(nv_store_go), .nv_recall_go(nv_recall_go)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: a strobe of this kind is due after the next edge
    task automatic expect_go(int kind, string req);
        exp_kind.push_back(kind);
        exp_cyc.push_back(cyc + 1);
        exp_req.push_back(req);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: every strobe must match the head of the queue
    always @(negedge clk) begin
        if (!rst && (nv_store_go || nv_recall_go)) begin
            got_kind = (nv_store_go ? K_STORE : 0) + (nv_recall_go ? K_RECALL : 0);
            if (exp_kind.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R4 R9: unexpected strobe kind %0d at cycle %0d, expected none",
                         got_kind, cyc);
            end else begin
                chk(exp_req[0], got_kind, exp_kind[0]);
                chk(exp_req[0], cyc, exp_cyc[0]);
                void'(exp_kind.pop_front());
                void'(exp_cyc.pop_front());
                void'(exp_req.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic power_up();
        supply_ok = 1'b1;
        expect_go(K_RECALL, "R1");
        tick(1);
        chk("R1", busy, 1);
        chk("R1", access_off, 1);
        tick(TFA - 1);
        chk("R1", busy, 1);
        tick(1);
        chk("R1", busy, 0);
        chk("R1", access_off, 0);
    endtask

    initial begin
        rst = 1'b1; supply_ok = 1'b0; cs_n = 1'b1; wr_pending = 1'b0; wr_pulse = 1'b0;
        cmd_store = 1'b0; cmd_recall = 1'b0; cmd_as_on = 1'b0; cmd_as_off = 1'b0;
        tick(3);
        chk("R1", access_off, 1);
        chk("R6", busy, 0);
        chk("R5", standby, 0);
        rst = 1'b0;
        tick(1);

        // first power-up, with a store attempt during the recall (R9)
        supply_ok = 1'b1;
        expect_go(K_RECALL, "R1");
        tick(1);
        chk("R1", busy, 1);
        cmd_store = 1'b1;
        tick(1);
        cmd_store = 1'b0;
        tick(TFA - 2);
        chk("R1", busy, 1);
        tick(1);
        chk("R1", busy, 0);
        chk("R1", access_off, 0);
        chk("R5", standby, 1);
        cs_n = 1'b0;
        tick(1);
        chk("R5", standby, 0);

        // software store, recall attempt during it ignored
        cmd_store = 1'b1;
        expect_go(K_STORE, "R6");
        tick(1);
        cmd_store = 1'b0;
        chk("R6", busy, 1);
        cmd_recall = 1'b1;
        tick(1);
        cmd_recall = 1'b0;
        tick(TSTORE - 2);
        chk("R6", busy, 1);
        cs_n = 1'b1;
        #2;
        chk("R5", standby, 0);
        tick(1);
        chk("R6", busy, 0);
        chk("R5", standby, 1);

        // both commands together: store wins
        cmd_store = 1'b1;
        cmd_recall = 1'b1;
        expect_go(K_STORE, "R9");
        tick(1);
        cmd_store = 1'b0;
        cmd_recall = 1'b0;
        tick(TSTORE);
        chk("R9", busy, 0);

        // software recall
        cmd_recall = 1'b1;
        expect_go(K_RECALL, "R6");
        tick(1);
        cmd_recall = 1'b0;
        chk("R6", busy, 1);
        tick(TRECALL - 1);
        chk("R6", busy, 1);
        tick(1);
        chk("R6", busy, 0);

        // R7: a store clears the dirty mark, so power loss saves nothing
        wr_pulse = 1'b1;
        tick(1);
        wr_pulse = 1'b0;
        cmd_store = 1'b1;
        expect_go(K_STORE, "R7");
        tick(1);
        cmd_store = 1'b0;
        tick(TSTORE);
        supply_ok = 1'b0;
        tick(1);
        chk("R2", access_off, 1);
        chk("R7", busy, 0);
        tick(2);

        // R4: dirty SRAM is saved on power loss
        power_up();
        wr_pulse = 1'b1;
        tick(1);
        wr_pulse = 1'b0;
        supply_ok = 1'b0;
        expect_go(K_STORE, "R4");
        tick(1);
        chk("R4", busy, 1);
        chk("R2", access_off, 1);
        tick(TSTORE - 1);
        chk("R4", busy, 1);
        tick(1);
        chk("R4", busy, 0);
        chk("R4", access_off, 1);

        // R8: saving disabled suppresses the store
        power_up();
        cmd_as_off = 1'b1;
        tick(1);
        cmd_as_off = 1'b0;
        wr_pulse = 1'b1;
        tick(1);
        wr_pulse = 1'b0;
        supply_ok = 1'b0;
        tick(1);
        chk("R8", busy, 0);
        chk("R8", access_off, 1);
        tick(2);

        // R8: power-up re-enables saving
        power_up();
        wr_pulse = 1'b1;
        tick(1);
        wr_pulse = 1'b0;
        supply_ok = 1'b0;
        expect_go(K_STORE, "R8");
        tick(1);
        chk("R8", busy, 1);
        tick(TSTORE);
        chk("R8", busy, 0);

        // R3: grace window, write inside it, command inside it ignored (R2)
        power_up();
        cmd_as_off = 1'b1;
        tick(1);
        cmd_as_off = 1'b0;
        cmd_as_on = 1'b1;
        tick(1);
        cmd_as_on = 1'b0;
        wr_pending = 1'b1;
        supply_ok = 1'b0;
        tick(1);
        wr_pending = 1'b0;
        chk("R3", access_off, 0);
        chk("R3", busy, 0);
        wr_pulse = 1'b1;
        cmd_store = 1'b1;
        tick(1);
        wr_pulse = 1'b0;
        cmd_store = 1'b0;
        tick(TDELAY - 2);
        chk("R3", access_off, 0);
        expect_go(K_STORE, "R3");
        tick(1);
        chk("R3", busy, 1);
        chk("R3", access_off, 1);
        tick(TSTORE);
        chk("R3", busy, 0);

        tick(3);
        while (exp_kind.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s: got no strobe expected kind %0d at cycle %0d",
                     exp_req[0], exp_kind[0], exp_cyc[0]);
            void'(exp_kind.pop_front());
            void'(exp_cyc.pop_front());
            void'(exp_req.pop_front());
        end
        finish_run();
    end
endmodule